// File: doc/BRIEF.md
# Address-Delta Pointer Load Value Predictor

This block guesses the value of a pointer-producing load when that load misses in the second-level cache while the core is running ahead speculatively. Many pointer loads return a value that sits a fixed distance from their own address, because nodes and the objects they point at are laid out regularly in memory. The block learns that distance, called the delta (effective address minus loaded value), for each load instruction address (PC). It then predicts the value as the load's effective address minus the learned delta, so that dependent loads can form their addresses instead of being marked invalid.

Training comes from loads retiring in normal mode. Each retiring load supplies its PC, effective address and loaded value. Loads whose delta is large are treated as data loads and are never allocated, so the small table holds only address loads. Lookups come from runahead-mode cache misses and return a valid flag and a predicted value one cycle later. A wrong guess needs no recovery, because runahead results are discarded anyway. The table therefore keeps no history for rollback.

Top module: `avd_predictor`

## Requirements
- R1: After reset every table entry is invalid: `pred_valid` is 0, and a lookup of any PC returns `pred_valid` = 0.
- R2: A lookup presented in cycle t yields `pred_value` = `pred_addr` − stored delta (modulo 2^32) in cycle t+1, together with `pred_valid` = 1, when the entry qualifies under R4.
- R3: A training event whose delta (`train_addr` − `train_value`, read as a signed 32-bit number) is not strictly between −65536 and +65536 allocates no entry. A delta of ±65535 is accepted.
- R4: A newly allocated entry has confidence 0. A training event with an unchanged delta raises the confidence by one, saturating at 3. A lookup predicts only when the confidence is 2 or more.
- R5: A training event with an in-range delta that differs from the stored one replaces the stored delta and clears the confidence to 0.
- R6: A training event with an out-of-range delta for a PC that has a valid entry invalidates that entry.
- R7: The set is chosen by PC bits [3:2] and the tag is PC bits [31:4]. There are 4 sets of 4 ways, and entries in different sets do not affect one another.
- R8: A missing in-range PC is placed in the lowest-numbered invalid way of its set. If there is none, it replaces the way least recently allocated or trained.
- R9: `pred_valid` is 0 in the cycle after a cycle with no lookup request, and after a lookup whose tag matches no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_valid | input | 1 | A load retires in normal mode this cycle |
| train_pc | input | 32 | PC of the retiring load |
| train_addr | input | 32 | Effective address of the retiring load |
| train_value | input | 32 | Value the retiring load returned |
| pred_req | input | 1 | A runahead load missed in the second-level cache this cycle |
| pred_pc | input | 32 | PC of the missing load |
| pred_addr | input | 32 | Effective address of the missing load |
| pred_valid | output | 1 | Registered: a confident prediction is available |
| pred_value | output | 32 | Registered predicted load value |

## Verification
The assertions assume a clean, active-low synchronous reset at start-up. They also assume that `pred_req` is low while reset is held, so that the one-cycle look-back at the request is meaningful. Training and lookup may arrive in the same cycle, and a lookup then reads the table as it stood before that cycle's update. The stimulus always drives the request strobes low during reset. It presents training and lookup in separate cycles, so each expected result follows from the order of events alone. All inputs change on the falling edge, half a cycle away from the sampling edge.

// File: rtl/avd_pkg.sv
package avd_pkg;
    localparam int ADDR_W  = 32;
    localparam int SET_W   = 2;
    localparam int WAY_W   = 2;
    localparam int SETS    = 1 << SET_W;
    localparam int WAYS    = 1 << WAY_W;
    localparam int ENTRIES = SETS * WAYS;
    localparam int TAG_W   = ADDR_W - 2 - SET_W;
    localparam int CONF_W  = 2;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] delta;
        logic [CONF_W-1:0] conf;
    } avd_entry_t;
endpackage

// File: rtl/avd_delta_filter.sv
module avd_delta_filter
    import avd_pkg::*;
#(
    parameter int MAX_DELTA = 65536
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] delta,
    output logic              in_range
);
    localparam logic signed [ADDR_W:0] LIMIT = (ADDR_W+1)'(MAX_DELTA);

    logic signed [ADDR_W:0] wide_delta;

    always_comb begin
        delta      = addr - value;
        wide_delta = {delta[ADDR_W-1], delta};
        in_range   = (wide_delta < LIMIT) && (wide_delta > -LIMIT);
    end
endmodule

// File: rtl/avd_lru_set.sv
module avd_lru_set
    import avd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    localparam logic [WAY_W-1:0] OLDEST = {WAY_W{1'b1}};

    logic [WAYS-1:0][WAY_W-1:0] age_d, age_q;
    logic [WAYS-1:0]            is_old;

    always_comb begin
        age_d  = age_q;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            is_old[w] = (age_q[w] == OLDEST);
            if (is_old[w]) victim = WAY_W'(w);
        end
        if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_d[w] = '0;
                else if (age_q[w] < age_q[touch_way])
                    age_d[w] = age_q[w] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(WAYS - 1 - w);
        end else begin
            age_q <= age_d;
        end
    end

    assert_single_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1)
        else $error("LRU ages of a set no longer form a permutation");
endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
    import avd_pkg::*;
#(
    parameter int MAX_DELTA   = 65536,
    parameter int CONF_THRESH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_valid,
    input  logic [ADDR_W-1:0] train_pc,
    input  logic [ADDR_W-1:0] train_addr,
    input  logic [ADDR_W-1:0] train_value,
    input  logic              pred_req,
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_value
);
    localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
    localparam logic [CONF_W-1:0] CONF_MIN = CONF_W'(CONF_THRESH);

    typedef struct packed {
        avd_entry_t [ENTRIES-1:0] tbl;
        logic                     pred_valid;
        logic [ADDR_W-1:0]        pred_value;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0]           train_delta;
    logic                        train_ok;
    logic [SETS-1:0]             touch_en;
    logic [WAY_W-1:0]            touch_way;
    logic [SETS-1:0][WAY_W-1:0]  victim_way;
    logic                        train_hit;
    logic [ENTRIES-1:0]          valid_vec;
    logic                        dup_tag;

    avd_delta_filter #(.MAX_DELTA(MAX_DELTA)) u_filter (
        .addr     (train_addr),
        .value    (train_value),
        .delta    (train_delta),
        .in_range (train_ok)
    );

    for (genvar s = 0; s < SETS; s++) begin : g_lru
        avd_lru_set u_lru (
            .clk       (clk),
            .rst_n     (rst_n),
            .touch     (touch_en[s]),
            .touch_way (touch_way),
            .victim    (victim_way[s])
        );
    end

    always_comb begin
        logic [SET_W-1:0]       p_set, t_set;
        logic [TAG_W-1:0]       p_tag, t_tag;
        logic [WAY_W-1:0]       hit_way, free_way, use_way;
        logic                   have_free;
        logic [SET_W+WAY_W-1:0] slot;
        avd_entry_t             e;

        st_d            = st_q;
        st_d.pred_valid = 1'b0;
        st_d.pred_value = '0;
        touch_en        = '0;
        touch_way       = '0;

        p_set = pred_pc[2 +: SET_W];
        p_tag = pred_pc[ADDR_W-1 -: TAG_W];
        t_set = train_pc[2 +: SET_W];
        t_tag = train_pc[ADDR_W-1 -: TAG_W];

        // lookup reads the table as registered
        if (pred_req) begin
            for (int w = 0; w < WAYS; w++) begin
                e = st_q.tbl[{p_set, WAY_W'(w)}];
                if (e.valid && e.tag == p_tag && e.conf >= CONF_MIN) begin
                    st_d.pred_valid = 1'b1;
                    st_d.pred_value = pred_addr - e.delta;
                end
            end
        end

        train_hit = 1'b0;
        hit_way   = '0;
        have_free = 1'b0;
        free_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            e = st_q.tbl[{t_set, WAY_W'(w)}];
            if (e.valid && e.tag == t_tag) begin
                train_hit = 1'b1;
                hit_way   = WAY_W'(w);
            end
            if (!e.valid && !have_free) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end

        use_way = train_hit ? hit_way : (have_free ? free_way : victim_way[t_set]);
        slot    = {t_set, use_way};

        if (train_valid) begin
            if (train_hit) begin
                if (train_ok) begin
                    if (st_q.tbl[slot].delta == train_delta) begin
                        if (st_q.tbl[slot].conf != CONF_MAX)
                            st_d.tbl[slot].conf = st_q.tbl[slot].conf + 1'b1;
                    end else begin
                        st_d.tbl[slot].delta = train_delta;
                        st_d.tbl[slot].conf  = '0;
                    end
                    touch_en[t_set] = 1'b1;
                    touch_way       = use_way;
                end else begin
                    st_d.tbl[slot].valid = 1'b0;
                end
            end else if (train_ok) begin
                st_d.tbl[slot].valid = 1'b1;
                st_d.tbl[slot].tag   = t_tag;
                st_d.tbl[slot].delta = train_delta;
                st_d.tbl[slot].conf  = '0;
                touch_en[t_set]      = 1'b1;
                touch_way            = use_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_valid = st_q.pred_valid;
    assign pred_value = st_q.pred_value;

    // observation of the table for the checks below
    always_comb begin
        dup_tag = 1'b0;
        for (int i = 0; i < ENTRIES; i++) valid_vec[i] = st_q.tbl[i].valid;
        for (int s = 0; s < SETS; s++)
            for (int a = 0; a < WAYS; a++)
                for (int b = a + 1; b < WAYS; b++)
                    if (st_q.tbl[s*WAYS+a].valid && st_q.tbl[s*WAYS+b].valid &&
                        st_q.tbl[s*WAYS+a].tag == st_q.tbl[s*WAYS+b].tag)
                        dup_tag = 1'b1;
    end

    assert_pred_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> $past(pred_req))
        else $error("prediction without a lookup request");

    assert_filtered_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && !train_ok) |=> $countones(valid_vec) <= $past($countones(valid_vec)))
        else $error("out-of-range training grew the table");

    assert_drop_on_large_delta_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && !train_ok && train_hit) |=>
            $countones(valid_vec) == $past($countones(valid_vec)) - 1)
        else $error("out-of-range training kept its entry");

    assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_tag)
        else $error("same tag held twice in one set");
endmodule

// File: tb/avd_predictor_test.sv
module avd_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        train_valid;
    logic [31:0] train_pc, train_addr, train_value;
    logic        pred_req;
    logic [31:0] pred_pc, pred_addr;
    logic        pred_valid;
    logic [31:0] pred_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    avd_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .train_valid(train_valid), .train_pc(train_pc),
        .train_addr(train_addr), .train_value(train_value),
        .pred_req(pred_req), .pred_pc(pred_pc), .pred_addr(pred_addr),
        .pred_valid(pred_valid), .pred_value(pred_value)
    );

    task automatic train(input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] val);
        @(negedge clk);
        train_valid = 1'b1; train_pc = pc; train_addr = addr; train_value = val;
        @(negedge clk);
        train_valid = 1'b0;
    endtask

    task automatic train_n(input int n, input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] val);
        for (int i = 0; i < n; i++) train(pc, addr, val);
    endtask

    task automatic expect_pred(input string req, input logic [31:0] pc, input logic [31:0] addr,
                               input bit exp_v, input logic [31:0] exp_val);
        @(negedge clk);
        pred_req = 1'b1; pred_pc = pc; pred_addr = addr;
        @(negedge clk);
        pred_req = 1'b0;
        checks++;
        if (pred_valid !== exp_v || (exp_v && pred_value !== exp_val)) begin
            errors++;
            $display("FAIL %s: pc=%h valid=%b value=%h expected valid=%b value=%h",
                     req, pc, pred_valid, pred_value, exp_v, exp_val);
        end
    endtask

    task automatic test_reset();
        checks++;
        if (pred_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: pred_valid=%b expected 0", pred_valid);
        end
        expect_pred("R1", 32'h0000_1000, 32'h100, 1'b0, 32'h0);
    endtask

    task automatic test_confidence();
        // delta 0x100
        train(32'h1000, 32'h2000, 32'h1F00);
        expect_pred("R4 conf0", 32'h1000, 32'h5000, 1'b0, 32'h0);
        train(32'h1000, 32'h2000, 32'h1F00);
        expect_pred("R4 conf1", 32'h1000, 32'h5000, 1'b0, 32'h0);
        train(32'h1000, 32'h2000, 32'h1F00);
        expect_pred("R2 conf2", 32'h1000, 32'h5000, 1'b1, 32'h4F00);
        train_n(3, 32'h1000, 32'h2000, 32'h1F00);
        expect_pred("R4 saturate", 32'h1000, 32'h0000_0040, 1'b1, 32'hFFFF_FF40);
    endtask

    task automatic test_retrain();
        // delta -8 replaces 0x100
        train(32'h1000, 32'h3000, 32'h3008);
        expect_pred("R5 cleared", 32'h1000, 32'h100, 1'b0, 32'h0);
        train_n(2, 32'h1000, 32'h3000, 32'h3008);
        expect_pred("R5 new delta", 32'h1000, 32'h100, 1'b1, 32'h108);
    endtask

    task automatic test_range();
        train_n(3, 32'h2004, 32'h0001_0000, 32'h0);
        expect_pred("R3 +65536", 32'h2004, 32'h0001_0000, 1'b0, 32'h0);
        train_n(3, 32'h2008, 32'h0001_0000, 32'h1);
        expect_pred("R3 +65535", 32'h2008, 32'h0002_0000, 1'b1, 32'h0001_0001);
        train_n(3, 32'h200C, 32'h0, 32'h0001_0000);
        expect_pred("R3 -65536", 32'h200C, 32'h0, 1'b0, 32'h0);
        train_n(3, 32'h2010, 32'h1, 32'h0001_0000);
        expect_pred("R3 -65535", 32'h2010, 32'h10, 1'b1, 32'h0001_000F);
    endtask

    task automatic test_invalidate();
        train(32'h2008, 32'h0010_0000, 32'h0);
        expect_pred("R6 dropped", 32'h2008, 32'h0002_0000, 1'b0, 32'h0);
        train(32'h2008, 32'h0001_0000, 32'h1);
        expect_pred("R6 realloc conf0", 32'h2008, 32'h0002_0000, 1'b0, 32'h0);
    endtask

    task automatic test_sets();
        train_n(3, 32'h3000, 32'h500, 32'h400);
        train_n(3, 32'h3004, 32'h500, 32'h4F0);
        expect_pred("R7 set0", 32'h3000, 32'h1000, 1'b1, 32'h0F00);
        expect_pred("R7 set1", 32'h3004, 32'h1000, 1'b1, 32'h0FF0);
        expect_pred("R9 tag miss", 32'h3100, 32'h1000, 1'b0, 32'h0);
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (pred_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 idle: pred_valid=%b expected 0", pred_valid);
        end
    endtask

    task automatic test_replace();
        train_n(3, 32'h400C, 32'h800, 32'h7F0);
        train(32'h401C, 32'h800, 32'h7E0);
        train(32'h402C, 32'h800, 32'h7D0);
        train(32'h403C, 32'h800, 32'h7C0);
        train(32'h400C, 32'h800, 32'h7F0);
        train(32'h404C, 32'h800, 32'h7B0);
        expect_pred("R8 recent kept", 32'h400C, 32'h900, 1'b1, 32'h8F0);
        train_n(2, 32'h401C, 32'h800, 32'h7E0);
        expect_pred("R8 oldest evicted", 32'h401C, 32'h900, 1'b0, 32'h0);
        train_n(2, 32'h404C, 32'h800, 32'h7B0);
        expect_pred("R8 newcomer kept", 32'h404C, 32'h900, 1'b1, 32'h8B0);
    endtask

    initial begin
        rst_n = 1'b0; train_valid = 1'b0; pred_req = 1'b0;
        train_pc = '0; train_addr = '0; train_value = '0;
        pred_pc = '0; pred_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_confidence();
        test_retrain();
        test_range();
        test_invalidate();
        test_sets();
        test_replace();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule